// File: doc/BRIEF.md
# Interrupt Split-Transaction Complete-Split Decision Unit

This block serves a high-speed USB host that visits a queue head carrying an interrupt split transaction. The caller presents the 8-bit micro-frame index and the queue head's fields: its split phase, its direction, its complete-split slot mask, its progress mask and its stored 5-bit frame tag. It also gives a recovery-path flag. From these the block picks one of four actions: skip, execute a complete-split, halt the queue head, or retry the start-split. It also returns the frame tag the queue head should hold next and a one-cycle strobe that reports a missed micro-frame.

The decision itself is combinational. The result is captured in one output register stage on a valid strobe, so it appears one clock after the request. The index splits into a slot number, which is bits [2:0], and an H-frame number, which is bits [7:3]. The frame tag tracks the H-frame number and wraps modulo 32, so a complete-split window that crosses an H-frame boundary keeps a coherent tag. Walking the schedule, moving data and accessing memory are left to the surrounding host logic.

Top module: `csplit_sched`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released with no request, `res_vld_o`=0, `res_act_o`=0 (skip), `res_tag_o`=0 and `res_miss_o`=0.
- R2: The action codes are 0 = skip, 1 = execute complete-split, 2 = halt, 3 = retry start-split. `phase_i`=0 means the start-split phase is moving into the complete-split phase. `phase_i`=1 means the queue head is already in the complete-split phase. `pid_i`=0 means IN and `pid_i`=1 means OUT.
- R3: With `phase_i`=0 and `recov_i`=0, the action is skip and the miss strobe is 0. The new tag is H-frame+1 (mod 32) when the slot is 6 or 7, and the H-frame number otherwise.
- R4: With `phase_i`=1, when `csmask_i` bit [slot] is clear, the action is skip, the tag returned equals `tag_i` and the miss strobe is 0.
- R5: With `phase_i`=1 and the slot scheduled, the progress check fails when the slot is nonzero, `csmask_i` bit [slot-1] is set and `prog_i` bit [slot-1] is clear. That case gives halt for IN or retry for OUT, miss strobe 1, and tag equal to `tag_i`.
- R6: With `phase_i`=1, the slot scheduled and the progress check passing, a `tag_i` different from the H-frame number gives the same halt/retry result with miss strobe 1 and tag equal to `tag_i`.
- R7: With `phase_i`=1, the slot scheduled, progress passing and the tag matching, a degenerate miss is flagged when `prog_i` is all zero and some `csmask_i` bit below slot-1 is set. It gives the same halt/retry result with miss strobe 1 and tag equal to `tag_i`.
- R8: With `phase_i`=1 and none of the R4 to R7 conditions present, the action is execute complete-split with miss strobe 0. The new tag is H-frame+1 (mod 32) when the slot is 7, and the H-frame number otherwise.
- R9: With `recov_i`=1 and `phase_i`=0, the queue head is deferred: skip, tag equal to `tag_i`, miss strobe 0. No start-split action is ever produced. With `recov_i`=1 and `phase_i`=1, the result is the same as in normal mode.
- R10: A request with `valid_i`=1 at a rising edge is reported from that edge on, with `res_vld_o`=1. After an edge with `valid_i`=0, `res_vld_o` and `res_miss_o` are 0, and `res_act_o` and `res_tag_o` hold their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| uframe_i | input | 8 | Micro-frame index (H-frame in [7:3], slot in [2:0]) |
| phase_i | input | 1 | Split phase: 0 start-to-complete move, 1 complete-split |
| pid_i | input | 1 | Direction: 0 IN, 1 OUT |
| csmask_i | input | 8 | Complete-split slot mask |
| prog_i | input | 8 | Progress mask of completed slots |
| tag_i | input | 5 | Stored frame tag |
| recov_i | input | 1 | Recovery-path mode |
| res_vld_o | output | 1 | Result valid, one cycle after the request |
| res_act_o | output | 2 | Chosen action code |
| res_tag_o | output | 5 | Frame tag to store |
| res_miss_o | output | 1 | Missed micro-frame strobe |

## Verification
A wrong internal decision, such as a slot decoded off by one, an H-frame carry lost at the 31-to-0 wrap, or a direction swapped, becomes visible on the result ports one clock after the request that triggers it. There is no hidden state that could delay the symptom. Errors can hide in specific index values, for example slot 6 versus slot 7 or H-frame 31. For that reason the bench sweeps every index under both phases and both directions against an independent model, and it adds directed cases for each error class and for the hold behaviour on idle cycles.

// File: rtl/csplit_pkg.sv
package csplit_pkg;

    typedef enum logic [1:0] {
        ACT_SKIP  = 2'd0,
        ACT_EXEC  = 2'd1,
        ACT_HALT  = 2'd2,
        ACT_RETRY = 2'd3
    } act_e;

    typedef enum logic {
        PH_START = 1'b0,
        PH_COMPL = 1'b1
    } phase_e;

    typedef enum logic {
        PID_IN  = 1'b0,
        PID_OUT = 1'b1
    } pid_e;

    typedef struct packed {
        logic sched;
        logic prog_fail;
        logic tag_fail;
        logic degen;
    } chk_t;

endpackage

// File: rtl/csplit_tag_rule.sv
module csplit_tag_rule #(
    parameter int IDX_W  = 8,
    parameter int SLOT_W = 3,
    localparam int TAG_W = IDX_W - SLOT_W
) (
    input  logic [IDX_W-1:0] uframe_i,
    input  logic             start_move_i,
    output logic [TAG_W-1:0] tag_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = {SLOT_W{1'b1}};
    localparam logic [SLOT_W-1:0] PENULT    = LAST_SLOT - 1'b1;

    logic [SLOT_W-1:0] slot;
    logic [TAG_W-1:0]  hframe;
    logic              bump;

    always_comb begin
        slot   = uframe_i[SLOT_W-1:0];
        hframe = uframe_i[IDX_W-1:SLOT_W];
        // Last slot always advances; the one before it advances only on entry
        bump   = (slot == LAST_SLOT) || (start_move_i && (slot == PENULT));
        tag_o  = hframe + TAG_W'(bump);
    end
endmodule

// File: rtl/csplit_check.sv
module csplit_check
    import csplit_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int SLOT_W = 3,
    localparam int TAG_W = IDX_W - SLOT_W,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic [IDX_W-1:0] uframe_i,
    input  logic [SLOTS-1:0] csmask_i,
    input  logic [SLOTS-1:0] prog_i,
    input  logic [TAG_W-1:0] tag_i,
    output chk_t             chk_o
);
    logic [SLOT_W-1:0] slot;
    logic [SLOT_W-1:0] prev;
    logic [TAG_W-1:0]  hframe;
    logic [SLOTS-1:0]  below_prev;

    always_comb begin
        slot   = uframe_i[SLOT_W-1:0];
        prev   = slot - 1'b1;
        hframe = uframe_i[IDX_W-1:SLOT_W];
        for (int k = 0; k < SLOTS; k++) begin
            below_prev[k] = (slot != '0) && (k < int'(prev));
        end
        chk_o.sched     = csmask_i[slot];
        chk_o.prog_fail = (slot != '0) && csmask_i[prev] && !prog_i[prev];
        chk_o.tag_fail  = (tag_i != hframe);
        chk_o.degen     = (prog_i == '0) && |(csmask_i & below_prev);
    end
endmodule

// File: rtl/csplit_sched.sv
module csplit_sched
    import csplit_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int SLOT_W = 3,
    localparam int TAG_W = IDX_W - SLOT_W,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [IDX_W-1:0] uframe_i,
    input  logic             phase_i,
    input  logic             pid_i,
    input  logic [SLOTS-1:0] csmask_i,
    input  logic [SLOTS-1:0] prog_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic             recov_i,
    output logic             res_vld_o,
    output logic [1:0]       res_act_o,
    output logic [TAG_W-1:0] res_tag_o,
    output logic             res_miss_o
);
    typedef struct packed {
        logic             vld;
        act_e             act;
        logic [TAG_W-1:0] tag;
        logic             miss;
    } res_t;

    res_t             res_d, res_q;
    logic [TAG_W-1:0] rule_tag;
    chk_t             chk;
    logic             is_start;
    logic             any_err;
    act_e             err_act;

    assign is_start = (phase_e'(phase_i) == PH_START);

    csplit_tag_rule #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_tag (
        .uframe_i    (uframe_i),
        .start_move_i(is_start),
        .tag_o       (rule_tag)
    );

    csplit_check #(.IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_chk (
        .uframe_i(uframe_i),
        .csmask_i(csmask_i),
        .prog_i  (prog_i),
        .tag_i   (tag_i),
        .chk_o   (chk)
    );

    always_comb begin
        any_err = chk.prog_fail || chk.tag_fail || chk.degen;
        err_act = (pid_e'(pid_i) == PID_OUT) ? ACT_RETRY : ACT_HALT;

        res_d      = res_q;
        res_d.vld  = valid_i;
        res_d.miss = 1'b0;
        if (valid_i) begin
            if (is_start) begin
                res_d.act = ACT_SKIP;
                res_d.tag = recov_i ? tag_i : rule_tag;
            end else if (!chk.sched) begin
                res_d.act = ACT_SKIP;
                res_d.tag = tag_i;
            end else if (any_err) begin
                res_d.act  = err_act;
                res_d.tag  = tag_i;
                res_d.miss = 1'b1;
            end else begin
                res_d.act = ACT_EXEC;
                res_d.tag = rule_tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{vld: 1'b0, act: ACT_SKIP, tag: '0, miss: 1'b0};
        end else begin
            res_q <= res_d;
        end
    end

    assign res_vld_o  = res_q.vld;
    assign res_act_o  = res_q.act;
    assign res_tag_o  = res_q.tag;
    assign res_miss_o = res_q.miss;

    // Miss strobe only accompanies an error action
    assert_miss_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
        res_miss_o |-> (res_act_o == ACT_HALT || res_act_o == ACT_RETRY));

    // Halt is reserved for IN queue heads
    assert_halt_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && res_act_o == ACT_HALT) |-> ($past(pid_i) == PID_IN));

    // Complete-split only in a scheduled slot
    assert_exec_sched_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && res_act_o == ACT_EXEC) |-> $past(csmask_i[uframe_i[SLOT_W-1:0]]));

    // Deferred entry in recovery keeps the stored tag
    assert_recov_defer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld_o && $past(recov_i) && !$past(phase_i))
            |-> (res_tag_o == $past(tag_i) && res_act_o == ACT_SKIP));

    // Idle cycle clears the strobes
    assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!res_miss_o && !res_vld_o));
endmodule

// File: tb/sim_csplit_sched.sv
module sim_csplit_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       valid_i = 1'b0;
    logic [7:0] uframe_i = '0;
    logic       phase_i = 1'b0;
    logic       pid_i = 1'b0;
    logic [7:0] csmask_i = '0;
    logic [7:0] prog_i = '0;
    logic [4:0] tag_i = '0;
    logic       recov_i = 1'b0;
    logic       res_vld_o;
    logic [1:0] res_act_o;
    logic [4:0] res_tag_o;
    logic       res_miss_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    csplit_sched u0 (.*);

    // Independent model written from the requirement text: {act, tag, miss}
    function automatic logic [7:0] model(input logic [7:0] idx, input logic ph,
                                         input logic pid, input logic [7:0] cm,
                                         input logic [7:0] pg, input logic [4:0] tg,
                                         input logic rec);
        int   s  = int'(idx[2:0]);
        logic [4:0] hf = idx[7:3];
        logic [1:0] errc = pid ? 2'd3 : 2'd2;
        logic bad;
        logic low;
        if (ph == 1'b0) begin
            if (rec) return {2'd0, tg, 1'b0};
            return {2'd0, (s >= 6) ? hf + 5'd1 : hf, 1'b0};
        end
        if (!cm[s]) return {2'd0, tg, 1'b0};
        low = 1'b0;
        for (int j = 0; j < s - 1; j++) if (cm[j]) low = 1'b1;
        bad = (s > 0 && cm[s-1] && !pg[s-1]) || (tg != hf) || (pg == 8'd0 && low);
        if (bad) return {errc, tg, 1'b1};
        return {2'd1, (s == 7) ? hf + 5'd1 : hf, 1'b0};
    endfunction

    task automatic check(input string req, input logic [1:0] ea, input logic [4:0] et,
                         input logic em, input logic ev);
        checks++;
        if (res_act_o !== ea || res_tag_o !== et || res_miss_o !== em || res_vld_o !== ev) begin
            errors++;
            $display("FAIL %s: actual act=%0d tag=%0d miss=%0d vld=%0d expected act=%0d tag=%0d miss=%0d vld=%0d",
                     req, res_act_o, res_tag_o, res_miss_o, res_vld_o, ea, et, em, ev);
        end
    endtask

    // Called at a falling edge: drive, cross one rising edge, check at the next falling edge
    task automatic apply(input string req, input logic [7:0] idx, input logic ph,
                         input logic pid, input logic [7:0] cm, input logic [7:0] pg,
                         input logic [4:0] tg, input logic rec);
        logic [7:0] e;
        valid_i = 1'b1; uframe_i = idx; phase_i = ph; pid_i = pid;
        csmask_i = cm; prog_i = pg; tag_i = tg; recov_i = rec;
        e = model(idx, ph, pid, cm, pg, tg, rec);
        @(negedge clk);
        check(req, e[7:6], e[5:1], e[0], 1'b1);
    endtask

    task automatic t_reset_R1();
        check("R1", 2'd0, 5'd0, 1'b0, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1", 2'd0, 5'd0, 1'b0, 1'b0);
    endtask

    task automatic t_entry_R3();
        apply("R3", 8'hFE, 1'b0, 1'b0, 8'h00, 8'h00, 5'd9, 1'b0);
        check("R3", 2'd0, 5'd0, 1'b0, 1'b1);          // slot 6 of H-frame 31 wraps
        apply("R3", 8'h2D, 1'b0, 1'b1, 8'hFF, 8'h00, 5'd1, 1'b0);
        check("R3", 2'd0, 5'd5, 1'b0, 1'b1);          // slot 5 keeps H-frame 5
        apply("R3", 8'h2F, 1'b0, 1'b0, 8'h00, 8'h00, 5'd1, 1'b0);
        check("R3", 2'd0, 5'd6, 1'b0, 1'b1);          // slot 7 advances
    endtask

    task automatic t_unsched_R4();
        apply("R4", 8'h13, 1'b1, 1'b0, 8'hF7, 8'h00, 5'd17, 1'b0);
        check("R4", 2'd0, 5'd17, 1'b0, 1'b1);
    endtask

    task automatic t_progress_R5();
        apply("R5", 8'h1B, 1'b1, 1'b0, 8'h0C, 8'h00, 5'd3, 1'b0);
        check("R5", 2'd2, 5'd3, 1'b1, 1'b1);          // IN halts
        apply("R5", 8'h1B, 1'b1, 1'b1, 8'h0C, 8'h00, 5'd3, 1'b0);
        check("R5", 2'd3, 5'd3, 1'b1, 1'b1);          // OUT retries
        apply("R5", 8'h18, 1'b1, 1'b0, 8'h81, 8'h00, 5'd3, 1'b0);
        check("R5", 2'd1, 5'd3, 1'b0, 1'b1);          // slot 0 has no progress check
    endtask

    task automatic t_tag_R6();
        apply("R6", 8'h12, 1'b1, 1'b1, 8'h06, 8'h02, 5'd5, 1'b0);
        check("R6", 2'd3, 5'd5, 1'b1, 1'b1);
        apply("R6", 8'h12, 1'b1, 1'b0, 8'h06, 8'h02, 5'd2, 1'b0);
        check("R6", 2'd1, 5'd2, 1'b0, 1'b1);          // tag matches: executes
    endtask

    task automatic t_degen_R7();
        apply("R7", 8'h0D, 1'b1, 1'b0, 8'h24, 8'h00, 5'd1, 1'b0);
        check("R7", 2'd2, 5'd1, 1'b1, 1'b1);
        apply("R7", 8'h0D, 1'b1, 1'b1, 8'h24, 8'h04, 5'd1, 1'b0);
        check("R7", 2'd1, 5'd1, 1'b0, 1'b1);          // progress seen: no miss
    endtask

    task automatic t_exec_R8();
        apply("R8", 8'hFF, 1'b1, 1'b0, 8'hC0, 8'hFF, 5'd31, 1'b0);
        check("R8", 2'd1, 5'd0, 1'b0, 1'b1);          // slot 7 of H-frame 31 wraps
        apply("R8", 8'hFE, 1'b1, 1'b0, 8'h60, 8'hFF, 5'd31, 1'b0);
        check("R8", 2'd1, 5'd31, 1'b0, 1'b1);         // slot 6 in phase 1 does not advance
    endtask

    task automatic t_recov_R9();
        apply("R9", 8'h46, 1'b0, 1'b1, 8'hFF, 8'h00, 5'd12, 1'b1);
        check("R9", 2'd0, 5'd12, 1'b0, 1'b1);
        apply("R9", 8'h1B, 1'b1, 1'b1, 8'h0C, 8'h00, 5'd3, 1'b1);
        check("R9", 2'd3, 5'd3, 1'b1, 1'b1);
    endtask

    task automatic t_idle_R10();
        apply("R10", 8'h1B, 1'b1, 1'b0, 8'h0C, 8'h00, 5'd3, 1'b0);
        valid_i = 1'b0; uframe_i = 8'h00; tag_i = 5'd20; phase_i = 1'b0;
        @(negedge clk);
        check("R10", 2'd2, 5'd3, 1'b0, 1'b0);
        @(negedge clk);
        check("R10", 2'd2, 5'd3, 1'b0, 1'b0);
    endtask

    task automatic t_sweep_R2();
        for (int i = 0; i < 256; i++) begin
            for (int m = 0; m < 4; m++) begin
                logic [7:0] idx = 8'(i);
                logic [7:0] cm  = 8'(i * 37) ^ 8'h5A;
                logic [7:0] pg  = (i % 5 == 0) ? 8'h00 : 8'(i * 11);
                logic [4:0] tg  = (i % 3 == 0) ? idx[7:3] ^ 5'(i) : idx[7:3];
                apply("R2", idx, m[1], m[0], cm, pg, tg, 1'(i % 7 == 0));
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10: watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset_R1();
        t_entry_R3();
        t_unsched_R4();
        t_progress_R5();
        t_tag_R6();
        t_degen_R7();
        t_exec_R8();
        t_recov_R9();
        t_idle_R10();
        t_sweep_R2();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule